// File: doc/BRIEF.md
# Byte-Lane Synchronous SRAM with Selectable Read Latency

This block is a small clocked memory array organised as words of several byte lanes (by default 256 words of four 9-bit lanes). Chip selects, address, write data and write controls are captured on the rising clock edge. A write can touch any subset of lanes: each lane has its own select bit, qualified by a shared lane-write enable. A separate global-write input updates every lane of the word and overrides the lane controls.

Any selected cycle that writes no lane is a read. A mode input picks how read data reaches the output. In flow-through mode the word appears in the cycle right after the capturing edge. In pipelined mode it passes through one more output register and appears one cycle later. An output-enable input gates the data drivers without waiting for a clock. A read made with the drivers disabled still runs internally, so a write can follow it directly with no idle cycle between them.

Top module: `bw_sram`

## Requirements
- R1: A lane is written only when the lane-write enable `lane_wr_en` and that lane's bit in `lane_sel` are both 1. Lane i occupies data bits [9i+8:9i]. With `lane_wr_en` at 0 and `wr_all` at 0, no lane changes and the cycle is a read.
- R2: When `wr_all` is 1 in a selected cycle, all lanes of the addressed word take `wdata`, whatever `lane_wr_en` and `lane_sel` are.
- R3: With `pipe_mode` at 0, the word read at a capturing edge is driven on `rdata` in the clock cycle that follows that edge.
- R4: With `pipe_mode` at 1, the word is driven one cycle later than in R3. It holds the array contents from before any write made in the cycle right after the read.
- R5: A cycle is selected only when `cs_en` is 1, `cs_hi` is 1 and `cs_lo` is 0. Any other combination writes nothing, and the output drivers are off at the time that cycle's read data would have appeared.
- R6: `oe` acts without a clock. At 0 it switches the drivers off at once, and at 1 it turns them on only while read data is being presented. `rd_drive` reports the driver state, and `rdata` is high impedance while it is 0.
- R7: Write cycles never turn the drivers on. A read made with `oe` at 0 still completes, and a write to the same word may follow it in the next cycle.
- R8: While `rst_n` is low, and after it is released, the drivers stay off until a read presents data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control and output stages |
| cs_en | input | 1 | Select, must be 1 |
| cs_hi | input | 1 | Select, must be 1 |
| cs_lo | input | 1 | Select, must be 0 |
| addr | input | 8 | Word address |
| wdata | input | 36 | Write data, lane i at bits [9i+8:9i] |
| lane_wr_en | input | 1 | Qualifier for the per-lane selects |
| lane_sel | input | 4 | Per-lane write selects |
| wr_all | input | 1 | Global write of every lane |
| pipe_mode | input | 1 | 0 flow-through, 1 pipelined (tie high for the default) |
| oe | input | 1 | Asynchronous output enable, active high |
| rdata | output | 36 | Read data, high impedance when not driven |
| rd_drive | output | 1 | 1 while the data drivers are on |

## Verification
Lane writes are tried with sparse lane masks, with the enable low and every lane bit set, and with a global write that comes with a single lane bit. Together these separate a qualified lane write, an ignored lane select and the global override. Each selected combination and each deselecting combination of the three chip selects is applied with a global write. A read-back then shows whether any of them reached the array. Reads sit back to back with writes to the same word and at both ends of the address range. A run in each latency mode shows at which cycle the data appears and whether the pipelined stage captured the value from before or after the write. Toggling the output enable partway through a cycle, and making a read with it low, separates driver gating from the clocked read path.

// File: rtl/bw_sram_pkg.sv
`timescale 1ns/100ps
package bw_sram_pkg;
    typedef enum logic {
        RD_FLOW = 1'b0,
        RD_PIPE = 1'b1
    } rd_mode_e;
endpackage

// File: rtl/bw_wr_decode.sv
`timescale 1ns/100ps
module bw_wr_decode #(
    parameter int LANES = 4
) (
    input  logic             sel,
    input  logic             lane_wr_en,
    input  logic [LANES-1:0] lane_sel,
    input  logic             wr_all,
    output logic [LANES-1:0] wr_mask,
    output logic             rd_req
);
    genvar l;
    generate
        for (l = 0; l < LANES; l++) begin : g_lane
            // global write wins over the qualified per-lane select
            assign wr_mask[l] = sel & (wr_all | (lane_wr_en & lane_sel[l]));
        end
    endgenerate

    // a selected cycle that changes no lane is a read
    assign rd_req = sel & ~(|wr_mask);
endmodule

// File: rtl/bw_array.sv
`timescale 1ns/100ps
module bw_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        wr_mask,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    genvar l;
    generate
        for (l = 0; l < LANES; l++) begin : g_bank
            logic [LANE_W-1:0] bank [DEPTH];

            always_ff @(posedge clk) begin
                if (wr_mask[l]) begin
                    bank[waddr] <= wdata[l*LANE_W +: LANE_W];
                end
            end

            assign rdata[l*LANE_W +: LANE_W] = bank[raddr];
        end
    endgenerate
endmodule

// File: rtl/bw_rd_path.sv
`timescale 1ns/100ps
module bw_rd_path
    import bw_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              pipe_mode,
    input  logic              oe,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [ADDR_W-1:0] arr_raddr,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_drive
);
    typedef struct packed {
        logic              act1;
        logic [ADDR_W-1:0] addr1;
        logic              act2;
        logic [DATA_W-1:0] dout2;
    } rd_state_t;

    rd_state_t st_d, st_q;
    rd_mode_e  mode;
    logic              present;
    logic [DATA_W-1:0] word;

    always_comb begin
        st_d      = st_q;
        st_d.act1 = rd_req;
        if (rd_req) begin
            st_d.addr1 = addr;
        end
        st_d.act2 = st_q.act1;
        if (st_q.act1) begin
            st_d.dout2 = arr_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign arr_raddr = st_q.addr1;
    assign mode      = rd_mode_e'(pipe_mode);

    always_comb begin
        case (mode)
            RD_PIPE: begin
                present = st_q.act2;
                word    = st_q.dout2;
            end
            default: begin
                present = st_q.act1;
                word    = arr_rdata;
            end
        endcase
    end

    assign rd_drive = oe & present;
    assign rdata    = rd_drive ? word : 'z;

    AST_OE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> !rd_drive); // R6

    AST_FLOW_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && oe && !pipe_mode) |=> (rd_drive || pipe_mode || !oe)); // R3

    AST_PIPE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && pipe_mode) ##1 pipe_mode ##1 (pipe_mode && oe) |-> rd_drive); // R4
endmodule

// File: rtl/bw_sram.sv
`timescale 1ns/100ps
module bw_sram #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_en,
    input  logic                    cs_hi,
    input  logic                    cs_lo,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    lane_wr_en,
    input  logic [LANES-1:0]        lane_sel,
    input  logic                    wr_all,
    input  logic                    pipe_mode,
    input  logic                    oe,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rd_drive
);
    localparam int DATA_W = LANES * LANE_W;

    logic              sel;
    logic [LANES-1:0]  wr_mask;
    logic              rd_req;
    logic [ADDR_W-1:0] arr_raddr;
    logic [DATA_W-1:0] arr_rdata;

    assign sel = cs_en & cs_hi & ~cs_lo;

    bw_wr_decode #(.LANES(LANES)) u_dec (
        .sel        (sel),
        .lane_wr_en (lane_wr_en),
        .lane_sel   (lane_sel),
        .wr_all     (wr_all),
        .wr_mask    (wr_mask),
        .rd_req     (rd_req)
    );

    AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_en && cs_hi && !cs_lo && wr_all) |-> (&wr_mask)); // R2

    AST_LANE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_all && !lane_wr_en) |-> (wr_mask == '0)); // R1

    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs_en && cs_hi && !cs_lo) |-> (wr_mask == '0 && !rd_req)); // R5

    bw_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_arr (
        .clk     (clk),
        .wr_mask (wr_mask),
        .waddr   (addr),
        .wdata   (wdata),
        .raddr   (arr_raddr),
        .rdata   (arr_rdata)
    );

    bw_rd_path #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (rd_req),
        .addr      (addr),
        .pipe_mode (pipe_mode),
        .oe        (oe),
        .arr_rdata (arr_rdata),
        .arr_raddr (arr_raddr),
        .rdata     (rdata),
        .rd_drive  (rd_drive)
    );

    AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((|wr_mask) && !pipe_mode) |=> (!rd_drive || pipe_mode)); // R7
endmodule

// File: tb/sim_bw_sram.sv
`timescale 1ns/100ps
module sim_bw_sram;
    localparam int AW = 8;
    localparam int LN = 4;
    localparam int LW = 9;
    localparam int DW = LN * LW;
    localparam logic [2:0] ON = 3'b110;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          cs_en = 1'b0, cs_hi = 1'b0, cs_lo = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          lane_wr_en = 1'b0;
    logic [LN-1:0] lane_sel = '0;
    logic          wr_all = 1'b0;
    logic          pipe_mode = 1'b0;
    logic          oe = 1'b1;
    wire  [DW-1:0] rdata;
    wire           rd_drive;

    bw_sram u0 (
        .clk(clk), .rst_n(rst_n), .cs_en(cs_en), .cs_hi(cs_hi), .cs_lo(cs_lo),
        .addr(addr), .wdata(wdata), .lane_wr_en(lane_wr_en), .lane_sel(lane_sel),
        .wr_all(wr_all), .pipe_mode(pipe_mode), .oe(oe),
        .rdata(rdata), .rd_drive(rd_drive)
    );

    typedef struct {
        int            tgt;
        bit            drv;
        logic [DW-1:0] d;
        string         tag;
    } exp_t;

    exp_t          sb[$];
    logic [DW-1:0] ref_mem [1 << AW];
    int            cyc = 0;
    int            n_chk = 0;
    int            n_fail = 0;
    bit            done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag,
                         input logic [DW:0] act, input logic [DW:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // driver: apply one cycle of inputs and queue what the output must show
    task automatic step(input logic [2:0] cs, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd, input logic be,
                        input logic [LN-1:0] ls, input logic wa,
                        input bit chk, input string tag);
        logic          sel;
        logic [LN-1:0] m;
        exp_t          e;
        {cs_en, cs_hi, cs_lo} = cs;
        addr = a; wdata = wd; lane_wr_en = be; lane_sel = ls; wr_all = wa;
        sel = cs[2] & cs[1] & ~cs[0];
        m   = wa ? '1 : (be ? ls : '0);
        if (!sel) m = '0;
        if (chk) begin
            e.tgt = cyc + (pipe_mode ? 2 : 1);
            e.drv = sel && (m == '0) && oe;
            e.d   = ref_mem[a];
            e.tag = tag;
            sb.push_back(e);
        end
        for (int l = 0; l < LN; l++) begin
            if (m[l]) ref_mem[a][l*LW +: LW] = wd[l*LW +: LW];
        end
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(3'b000, '0, '0, 1'b0, '0, 1'b0, 1'b0, "idle");
    endtask

    // monitor: compare queued expectations half a cycle after each edge
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].tgt <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            if (e.tgt != cyc) begin
                check(1'b0, {e.tag, " missed"}, DW'(cyc), DW'(e.tgt));
            end else begin
                check(rd_drive === e.drv, {e.tag, " drive"},
                      {{DW{1'b0}}, rd_drive}, {{DW{1'b0}}, e.drv});
                if (e.drv) check(rdata === e.d, {e.tag, " data"},
                                 {1'b0, rdata}, {1'b0, e.d});
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            check(1'b0, "watchdog", '0, '1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] va, vb, vc, vd;
        va = 36'h123456789;
        vb = 36'hFEDCBA987;
        vc = 36'h0AAAA5555;
        vd = 36'h5A5A5A5A5;
        for (int i = 0; i < (1 << AW); i++) ref_mem[i] = '0;

        repeat (3) @(posedge clk);
        #1;
        check(rd_drive === 1'b0, "R8 reset drive", {35'b0, rd_drive}, '0);
        rst_n = 1'b1;
        idle(1);
        check(rd_drive === 1'b0, "R8 after release", {35'b0, rd_drive}, '0);

        // flow-through mode
        pipe_mode = 1'b0; oe = 1'b1;
        step(ON, 8'd5, va, 1'b0, 4'b0000, 1'b1, 1'b1, "R2 global write no drive");
        step(ON, 8'd5, '0, 1'b0, 4'b0000, 1'b0, 1'b1, "R3 read after global");
        step(ON, 8'd5, vb, 1'b1, 4'b0101, 1'b0, 1'b1, "R1 lane write");
        step(ON, 8'd5, '0, 1'b0, 4'b0000, 1'b0, 1'b1, "R1 read lanes 0,2");
        step(ON, 8'd5, vc, 1'b0, 4'b1111, 1'b0, 1'b1, "R1 selects without enable");
        step(ON, 8'd5, vc, 1'b1, 4'b0001, 1'b1, 1'b1, "R2 global overrides lanes");
        step(ON, 8'd5, '0, 1'b0, 4'b0000, 1'b0, 1'b1, "R2 read after override");
        step(3'b111, 8'd5, va, 1'b0, 4'b0000, 1'b1, 1'b1, "R5 cs_lo high");
        step(3'b010, 8'd5, va, 1'b0, 4'b0000, 1'b1, 1'b1, "R5 cs_en low");
        step(3'b100, 8'd5, va, 1'b0, 4'b0000, 1'b1, 1'b1, "R5 cs_hi low");
        step(ON, 8'd5, '0, 1'b0, 4'b0000, 1'b0, 1'b1, "R5 word unchanged");
        step(3'b000, 8'd5, '0, 1'b0, 4'b0000, 1'b0, 1'b1, "R5 deselected read");
        step(ON, 8'd0, vb, 1'b0, 4'b0000, 1'b1, 1'b1, "R7 write addr 0");
        step(ON, 8'd255, vd, 1'b1, 4'b1111, 1'b0, 1'b1, "R1 write addr 255");
        step(ON, 8'd0, '0, 1'b0, 4'b0000, 1'b0, 1'b1, "R3 read addr 0");
        step(ON, 8'd255, '0, 1'b0, 4'b0000, 1'b0, 1'b1, "R3 read addr 255");

        // dummy read with drivers off, then write straight after it
        step(3'b000, '0, '0, 1'b0, '0, 1'b0, 1'b0, "idle");
        oe = 1'b0;
        step(ON, 8'd0, '0, 1'b0, 4'b0000, 1'b0, 1'b1, "R7 dummy read");
        step(ON, 8'd0, vd, 1'b0, 4'b0000, 1'b1, 1'b1, "R7 write after dummy");
        oe = 1'b1;
        step(3'b000, '0, '0, 1'b0, '0, 1'b0, 1'b1, "R7 idle");
        step(ON, 8'd0, '0, 1'b0, 4'b0000, 1'b0, 1'b1, "R7 read turnaround");

        // asynchronous output enable inside a cycle
        step(ON, 8'd0, '0, 1'b0, 4'b0000, 1'b0, 1'b0, "setup");
        {cs_en, cs_hi, cs_lo} = 3'b000;
        #0.2;
        check(rd_drive === 1'b1 && rdata === vd, "R6 driven before oe drop",
              {rd_drive, rdata}, {1'b1, vd});
        oe = 1'b0;
        #0.2;
        check(rd_drive === 1'b0, "R6 oe low turns off", {35'b0, rd_drive}, '0);
        oe = 1'b1;
        #0.2;
        check(rd_drive === 1'b1 && rdata === vd, "R6 oe high restores",
              {rd_drive, rdata}, {1'b1, vd});
        @(posedge clk);
        #1;

        // pipelined mode
        idle(2);
        pipe_mode = 1'b1;
        idle(3);
        step(ON, 8'd7, va, 1'b0, 4'b0000, 1'b1, 1'b1, "R4 pipe write");
        step(ON, 8'd7, '0, 1'b0, 4'b0000, 1'b0, 1'b1, "R4 pipe read");
        step(ON, 8'd7, vb, 1'b1, 4'b1010, 1'b0, 1'b1, "R4 write after read");
        step(ON, 8'd7, '0, 1'b0, 4'b0000, 1'b0, 1'b1, "R4 read merged word");
        step(ON, 8'd5, '0, 1'b0, 4'b0000, 1'b0, 1'b1, "R4 back to back read");
        step(3'b111, 8'd5, '0, 1'b0, 4'b0000, 1'b0, 1'b1, "R5 pipe deselect");
        step(ON, 8'd255, '0, 1'b0, 4'b0000, 1'b0, 1'b1, "R4 read addr 255");
        idle(4);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule